// File: doc/BRIEF.md
# Rollover Event Counter

This block counts qualified events. Each rising clock edge on which the count enable is high and the clear is low counts as one event. The count width is a parameter. The value at which the counter wraps is an input of the same width, so the caller can change it at run time. After reaching that value the counter does not return to zero: on the next event it goes to one. With a rollover value RO the output therefore runs 0, 1, …, RO, 1, 2, ….

A rollover flag goes high while the count sits at the rollover value. It drops on the next counted event. The flag is the direct output of a flip-flop. Its next value is computed from the next count, so the port carries no decode logic after the register.

A synchronous clear returns the count to zero and wins over the enable. An asynchronous active-low reset forces the same state at any moment.

Top module: `evt_rollover_counter`

## Requirements
- R1: While `rstN` is low, `count` is 0 and `rollFlag` is 0. This takes effect at once, without waiting for a clock edge.
- R2: A rising edge with `clear` high loads `count` with 0, whatever the value of `countEn`.
- R3: A rising edge with `countEn` high, `clear` low and `count` not equal to `rollVal` increments `count` by one.
- R4: A rising edge with both `countEn` and `clear` low leaves `count` and `rollFlag` unchanged.
- R5: A rising edge with `countEn` high, `clear` low and `count` equal to `rollVal` loads `count` with 1, not 0.
- R6: After each counted event, `rollFlag` is 1 exactly when the new `count` equals the `rollVal` present at that edge. Otherwise it is 0, so the flag drops on the event that follows a rollover.
- R7: `rollFlag` is registered: with no event and no clear, it keeps its value even when `rollVal` changes to match or to differ from `count`.
- R8: With `rollVal` equal to 1, every counted event after the first leaves `count` at 1 and `rollFlag` at 1.
- R9: If `count` is above `rollVal`, counted events keep incrementing. The count passes from the all-ones value to 0 and then follows the normal sequence up to `rollVal`.
- R10: A clear drives `rollFlag` to 0, even when the flag was high and `countEn` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear to zero, has priority over the enable |
| countEn | input | 1 | Event qualifier; high counts one event per edge |
| rollVal | input | CNT_BITS | Value after which the next event wraps the count to 1 |
| count | output | CNT_BITS | Current count |
| rollFlag | output | 1 | Registered flag, high while the count sits at the rollover value |

## Verification
The assertions assume that `clear`, `countEn` and `rollVal` are settled and known at every rising edge. They also assume that reset is released away from an edge. The properties compare the registers only against the values these inputs had at the previous edge. The stimulus changes every input on the falling clock edge. It asserts reset at an arbitrary point between edges and releases it on a falling edge, so every sampled value is the one the driver meant.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;

  // Per-edge action chosen by the control; at most one field is high.
  typedef struct packed {
    logic clr;   // load zero
    logic inc;   // add one
    logic wrap;  // load one
  } ctrlStrobes_t;

endpackage

// File: rtl/evt_cnt_ctrl.sv
module evt_cnt_ctrl
  import evt_cnt_pkg::*;
(
  input  logic         clear,
  input  logic         countEn,
  input  logic         atRoll,
  output ctrlStrobes_t strb
);

  logic evtQual;

  // Clear masks the enable, so it wins when both are high.
  assign evtQual = countEn & ~clear;

  always_comb begin
    strb      = '0;
    strb.clr  = clear;
    strb.inc  = evtQual & ~atRoll;
    strb.wrap = evtQual & atRoll;
  end

endmodule

// File: rtl/evt_cnt_path.sv
module evt_cnt_path
  import evt_cnt_pkg::*;
#(
  parameter int CNT_BITS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strb,
  input  logic [CNT_BITS-1:0] rollVal,
  output logic [CNT_BITS-1:0] countQ,
  output logic                flagQ,
  output logic                atRoll
);

  localparam logic [CNT_BITS-1:0] CNT_ZERO = '0;
  localparam logic [CNT_BITS-1:0] CNT_ONE  = CNT_BITS'(1);

  logic [CNT_BITS-1:0] nextCount;
  logic                nextFlag;
  logic                anyEvt;

  assign atRoll = (countQ == rollVal);
  assign anyEvt = strb.inc | strb.wrap;

  always_comb begin
    if (strb.clr)       nextCount = CNT_ZERO;
    else if (strb.wrap) nextCount = CNT_ONE;
    else if (strb.inc)  nextCount = countQ + CNT_ONE;
    else                nextCount = countQ;
  end

  // Flag decided from the next count, so the port is a bare register.
  always_comb begin
    if (strb.clr)    nextFlag = 1'b0;
    else if (anyEvt) nextFlag = (nextCount == rollVal);
    else             nextFlag = flagQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= CNT_ZERO;
      flagQ  <= 1'b0;
    end else begin
      countQ <= nextCount;
      flagQ  <= nextFlag;
    end
  end

  // R2, R10: clear empties the count and the flag
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (countQ == CNT_ZERO) && !flagQ);

  // R3: ordinary event adds one
  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.inc |=> countQ == $past(countQ) + CNT_ONE);

  // R5: event at the rollover value lands on one
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrap |=> countQ == CNT_ONE);

  // R4, R7: idle edges change nothing
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.clr | strb.inc | strb.wrap) |=> $stable(countQ) && $stable(flagQ));

  // R6: after an event the flag matches the new count against the old bound
  a_r6_flag: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inc | strb.wrap) |=> flagQ == (countQ == $past(rollVal)));

endmodule

// File: rtl/evt_rollover_counter.sv
module evt_rollover_counter
  import evt_cnt_pkg::*;
#(
  parameter int CNT_BITS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clear,
  input  logic                countEn,
  input  logic [CNT_BITS-1:0] rollVal,
  output logic [CNT_BITS-1:0] count,
  output logic                rollFlag
);

  ctrlStrobes_t strb;
  logic         atRoll;

  evt_cnt_ctrl ctrl_i (
    .clear   (clear),
    .countEn (countEn),
    .atRoll  (atRoll),
    .strb    (strb)
  );

  evt_cnt_path #(.CNT_BITS(CNT_BITS)) path_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rollVal (rollVal),
    .countQ  (count),
    .flagQ   (rollFlag),
    .atRoll  (atRoll)
  );

endmodule

// File: tb/evt_rollover_counter_tb_top.sv
`timescale 1ns/1ps
module evt_rollover_counter_tb_top;

  localparam int N = 4;

  typedef struct {
    logic [N-1:0] expCount;
    logic         expFlag;
    string        tag;
  } expItem_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         clear = 1'b0;
  logic         countEn = 1'b0;
  logic [N-1:0] rollVal = '0;
  logic [N-1:0] count;
  logic         rollFlag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  expItem_t     sbQ[$];
  logic [N-1:0] mCount = '0;
  logic         mFlag = 1'b0;

  always #4 clk = ~clk;

  evt_rollover_counter #(.CNT_BITS(N)) dut_i (
    .clk(clk), .rstN(rstN), .clear(clear), .countEn(countEn),
    .rollVal(rollVal), .count(count), .rollFlag(rollFlag)
  );

  task automatic compare(input logic [N-1:0] c, input logic f, input string tag);
    checks++;
    if (count !== c || rollFlag !== f) begin
      fails++;
      $display("FAIL %s: count=%0d flag=%0b expected count=%0d flag=%0b",
               tag, count, rollFlag, c, f);
    end
  endtask

  // Driver: apply one cycle of inputs and queue the expected result.
  task automatic step(input logic clr, input logic en, input logic [N-1:0] ro,
                      input string tag);
    expItem_t it;
    @(negedge clk);
    clear = clr; countEn = en; rollVal = ro;
    if (clr) begin
      mCount = '0; mFlag = 1'b0;
    end else if (en) begin
      mCount = (mCount == ro) ? N'(1) : mCount + N'(1);
      mFlag  = (mCount == ro);
    end
    it.expCount = mCount; it.expFlag = mFlag; it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic run(input int n, input logic [N-1:0] ro, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, ro, tag);
  endtask

  // Asynchronous reset applied between edges, after the monitor has drained.
  task automatic doReset(input string tag);
    @(posedge clk); #3;
    rstN = 1'b0;
    #2;
    compare('0, 1'b0, tag);
    @(negedge clk);
    clear = 1'b0; countEn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    mCount = '0; mFlag = 1'b0;
    #1;
    compare('0, 1'b0, tag);
  endtask

  // Monitor: pop one expected item after each edge.
  initial begin
    forever begin
      @(posedge clk); #2;
      if (sbQ.size() > 0) begin
        expItem_t it;
        it = sbQ.pop_front();
        compare(it.expCount, it.expFlag, it.tag);
      end
    end
  end

  initial begin
    #2;
    compare('0, 1'b0, "R1 power-on reset");
    @(negedge clk); rstN = 1'b1;

    // Non-power-of-two bound, continuous events
    run(12, N'(10), "R3/R5/R6 continuous ro=10");
    // Gapped events
    for (int i = 0; i < 16; i++) step(1'b0, i[0], N'(6), "R4/R6 gapped ro=6");
    // Clear together with enable mid-count
    run(3, N'(6), "R3 pre-clear");
    step(1'b1, 1'b1, N'(6), "R2 clear priority");
    step(1'b0, 1'b0, N'(6), "R4 hold after clear");
    // Reach the bound, then clear with enable while flag is high
    run(6, N'(6), "R6 reach ro=6");
    step(1'b1, 1'b1, N'(6), "R10 clear drops flag");
    // Registered flag: idle while the bound moves
    run(6, N'(6), "R6 reach ro=6 again");
    step(1'b0, 1'b0, N'(3), "R7 flag held high");
    step(1'b0, 1'b0, N'(9), "R7 flag held high");
    step(1'b0, 1'b1, N'(9), "R6 flag drops on event");
    step(1'b0, 1'b0, N'(7), "R7 flag held low");
    step(1'b0, 1'b1, N'(7), "R6 event onto bound");
    // Bound of one
    step(1'b1, 1'b0, N'(1), "R2 clear");
    run(5, N'(1), "R8 ro=1");
    // Count above the bound wraps through zero
    step(1'b1, 1'b0, N'(15), "R2 clear");
    run(12, N'(15), "R3 climb to 12");
    run(12, N'(5), "R9 above bound");
    // Bound of zero
    step(1'b1, 1'b0, N'(0), "R2 clear");
    run(4, N'(0), "R5 ro=0");
    // Full-range bound
    run(20, N'(15), "R5 ro=15");
    // Mid-run asynchronous reset
    run(3, N'(15), "R3 before reset");
    doReset("R1 async reset");
    run(4, N'(2), "R5 after reset");
    @(posedge clk); #3;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule